// File: doc/BRIEF.md
# Multiword Montgomery Modular Multiplier

This block computes the Montgomery product of two big integers, A·B·R⁻¹ mod M, where each operand is L words of 32 bits, L from 1 to 255, and R = 2^(32·L). The three operands stay in external memories that the block reads by word index. Each of these memories returns data one clock after the address is presented. The result is written out word by word through an address, data and write-enable port.

The datapath works radix-2. For every bit of B, from the least significant to the most significant, it forms a parity bit q. It then adds b·A and q·M to a running sum S in one word-serial pass, from the least significant word upward, and halves S in a second word-serial pass, from the most significant word downward. S lives in an internal scratch memory with one extra carry bit. A one-cycle `calculate` pulse while idle starts a run. `ready` reports that the block is idle again. No final subtraction of M is made, so the caller must keep 4M < R.

Top module: `mont_mul`

## Requirements
- R1: After reset `ready` is 1 and `resultWe` is 0.
- R2: A `calculate` pulse with nonzero `length` while `ready` is 1 drives `ready` to 0 in the next cycle.
- R3: For odd M with A < M, B < M and 4M < R, where R = 2^(32·length), the result r satisfies r·R ≡ A·B (mod M) and r < 2M.
- R4: Word index 0 of every operand and of the result is the most significant word, and index length−1 is the least significant word. While busy, every operand address stays within 0..length−1.
- R5: A run writes exactly `length` result words, one per `resultWe` cycle, at addresses 0, 1, …, length−1 in that order. Address and data are valid in the cycle `resultWe` is 1.
- R6: `resultWe` is never 1 while `ready` is 1, and `ready` rises only after the last result word has been written.
- R7: A `calculate` pulse while busy has no effect. The current run still writes exactly `length` words with a correct result, and no second run follows.
- R8: A `calculate` pulse with `length` equal to 0 is ignored. `ready` stays 1 and no word is written.
- R9: Exact values: L=1 with A=0x9, B=0x7, M=0x13 gives 0x1. L=1 with A=0x2, B=0xA, M=0xB gives 0x5. L=3 with A=1, B=0x4000, M=0x1ffffff_ffffffff_ffffffff gives 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| length | input | 8 | Operand size in 32-bit words, sampled on start |
| calculate | input | 1 | Start strobe, one cycle |
| ready | output | 1 | High while idle |
| opAAddr | output | 8 | Word index into the A memory |
| opAData | input | 32 | A word, one cycle after the address |
| opBAddr | output | 8 | Word index into the B memory |
| opBData | input | 32 | B word, one cycle after the address |
| opMAddr | output | 8 | Word index into the M memory |
| opMData | input | 32 | M word, one cycle after the address |
| resultAddr | output | 8 | Result word index |
| resultData | output | 32 | Result word |
| resultWe | output | 1 | Result write enable, one cycle per word |

## Verification
The assertions assume that the operand memories answer with exactly one cycle of latency and that `length` is stable during the cycle of a start pulse. The bench models the three memories as registered reads of vectors it holds unchanged for the whole run. The range and ordering properties also rely on M being odd and 4M < R, which keeps the carry out of the add pass at zero. Every vector in the stimulus table obeys these limits, with A and B below M, including the edge cases A = 0 and A = B = M−1.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef enum logic [2:0] {
    PASS_NONE,
    PASS_CLEAR,
    PASS_ADD,
    PASS_SHIFT,
    PASS_EMIT
  } passKind_e;

  typedef struct packed {
    logic      issue;
    passKind_e kind;
    logic      decide;
    logic      fold;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FETCH,
    ST_DECIDE,
    ST_ADD,
    ST_STALL,
    ST_SHIFT,
    ST_EMIT,
    ST_DONE
  } ctrlState_e;

endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int WordW = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     calculate,
  input  logic [AddrW-1:0]         length,
  output logic                     ready,
  output dpStrobe_t                strobe,
  output logic [AddrW-1:0]         wordIdx,
  output logic [AddrW-1:0]         bWordIdx,
  output logic [$clog2(WordW)-1:0] bitSel
);
  localparam int BitW    = $clog2(WordW);
  localparam int CntW    = AddrW + 1;
  localparam int BitCntW = AddrW + BitW;

  ctrlState_e          stateQ, stateN;
  logic [AddrW-1:0]    lenQ;
  logic [CntW-1:0]     cntQ;
  logic [BitCntW-1:0]  bitCntQ;
  logic [BitCntW-1:0]  lastBitIdx;
  logic                passDone;
  logic                lastBit;
  logic                inPass;

  assign passDone   = (cntQ == {1'b0, lenQ});
  assign lastBitIdx = {lenQ, {BitW{1'b0}}} - BitCntW'(1);
  assign lastBit    = (bitCntQ == lastBitIdx);
  assign inPass     = (stateQ == ST_CLEAR) || (stateQ == ST_ADD) ||
                      (stateQ == ST_SHIFT) || (stateQ == ST_EMIT);

  always_comb begin
    stateN = stateQ;
    case (stateQ)
      ST_IDLE:   if (calculate && (length != '0)) stateN = ST_CLEAR;
      ST_CLEAR:  if (passDone) stateN = ST_FETCH;
      ST_FETCH:  stateN = ST_DECIDE;
      ST_DECIDE: stateN = ST_ADD;
      ST_ADD:    if (passDone) stateN = ST_STALL;
      ST_STALL:  stateN = ST_SHIFT;
      ST_SHIFT:  if (passDone) stateN = lastBit ? ST_EMIT : ST_FETCH;
      ST_EMIT:   if (passDone) stateN = ST_DONE;
      ST_DONE:   stateN = ST_IDLE;
      default:   stateN = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.issue  = inPass && !passDone;
    strobe.decide = (stateQ == ST_DECIDE);
    strobe.fold   = (stateQ == ST_STALL);
    case (stateQ)
      ST_CLEAR: strobe.kind = PASS_CLEAR;
      ST_ADD:   strobe.kind = PASS_ADD;
      ST_SHIFT: strobe.kind = PASS_SHIFT;
      ST_EMIT:  strobe.kind = PASS_EMIT;
      default:  strobe.kind = PASS_NONE;
    endcase
  end

  // Additions walk from the least significant word (index len-1) upward;
  // shift, clear and emit walk from index 0 downward in significance.
  always_comb begin
    wordIdx = '0;
    if (stateQ == ST_FETCH) begin
      wordIdx = lenQ - AddrW'(1);
    end else if (strobe.issue) begin
      if (stateQ == ST_ADD) wordIdx = lenQ - AddrW'(1) - cntQ[AddrW-1:0];
      else                  wordIdx = cntQ[AddrW-1:0];
    end
  end

  assign bWordIdx = lenQ - AddrW'(1) - bitCntQ[BitCntW-1:BitW];
  assign bitSel   = bitCntQ[BitW-1:0];
  assign ready    = (stateQ == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      lenQ    <= '0;
      cntQ    <= '0;
      bitCntQ <= '0;
    end else begin
      stateQ <= stateN;
      if (stateN != stateQ)  cntQ <= '0;
      else if (strobe.issue) cntQ <= cntQ + CntW'(1);
      if (stateQ == ST_IDLE && stateN == ST_CLEAR) begin
        lenQ    <= length;
        bitCntQ <= '0;
      end else if (stateQ == ST_SHIFT && passDone && !lastBit) begin
        bitCntQ <= bitCntQ + BitCntW'(1);
      end
    end
  end

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ready && calculate && (length != '0)) |=> !ready);

  a_r8_zero_length_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ready && calculate && (length == '0)) |=> ready);

  a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && stateQ != ST_CLEAR && calculate) |=> (stateQ != ST_CLEAR));

  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (!ready) |-> ((wordIdx < lenQ) && (bWordIdx < lenQ)));

endmodule

// File: rtl/mont_dp.sv
module mont_dp
  import mont_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int WordW = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [AddrW-1:0]         wordIdx,
  input  logic [$clog2(WordW)-1:0] bitSel,
  input  logic [WordW-1:0]         opAData,
  input  logic [WordW-1:0]         opBData,
  input  logic [WordW-1:0]         opMData,
  output logic [AddrW-1:0]         resultAddr,
  output logic [WordW-1:0]         resultData,
  output logic                     resultWe
);
  localparam int Depth = 1 << AddrW;
  localparam int SumW  = WordW + 2;

  logic [WordW-1:0] sMem [Depth];
  logic [WordW-1:0] sRd;
  logic             pValid;
  passKind_e        pKind;
  logic [AddrW-1:0] pIdx;
  logic [1:0]       carryQ;
  logic             shInQ;
  logic             bQ, qQ;
  logic             bBit;
  logic [SumW-1:0]  addSum;
  logic             wrAdd, wrShift;

  assign bBit    = opBData[bitSel];
  assign wrAdd   = pValid && (pKind == PASS_ADD);
  assign wrShift = pValid && (pKind == PASS_SHIFT);
  assign addSum  = {2'b00, sRd}
                 + (bQ ? {2'b00, opAData} : SumW'(0))
                 + (qQ ? {2'b00, opMData} : SumW'(0))
                 + SumW'(carryQ);

  // Scratch store for S: registered read, same latency as the operand memories.
  always_ff @(posedge clk) begin
    sRd <= sMem[wordIdx];
    if (strobe.issue && strobe.kind == PASS_CLEAR) sMem[wordIdx] <= '0;
    if (wrAdd)   sMem[pIdx] <= addSum[WordW-1:0];
    if (wrShift) sMem[pIdx] <= {shInQ, sRd[WordW-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pValid <= 1'b0;
      pKind  <= PASS_NONE;
      pIdx   <= '0;
      carryQ <= '0;
      shInQ  <= 1'b0;
      bQ     <= 1'b0;
      qQ     <= 1'b0;
    end else begin
      pValid <= strobe.issue && (strobe.kind != PASS_CLEAR);
      pKind  <= strobe.kind;
      pIdx   <= wordIdx;
      if (strobe.decide) begin
        bQ     <= bBit;
        qQ     <= sRd[0] ^ (bBit & opAData[0]);
        carryQ <= '0;
      end else if (strobe.fold) begin
        shInQ  <= carryQ[0];
        carryQ <= '0;
      end else if (wrAdd) begin
        carryQ <= addSum[SumW-1:WordW];
      end else if (wrShift) begin
        shInQ  <= sRd[0];
      end
    end
  end

  assign resultWe   = pValid && (pKind == PASS_EMIT);
  assign resultAddr = pIdx;
  assign resultData = sRd;

  a_r5_first_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultWe) |-> (resultAddr == '0));

  a_r5_addr_ascends: assert property (@(posedge clk) disable iff (!rstN)
    (resultWe && $past(resultWe)) |-> (resultAddr == $past(resultAddr) + AddrW'(1)));

  a_r3_no_add_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fold |-> (carryQ[1] == 1'b0));

endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mont_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int WordW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] length,
  input  logic             calculate,
  output logic             ready,
  output logic [AddrW-1:0] opAAddr,
  input  logic [WordW-1:0] opAData,
  output logic [AddrW-1:0] opBAddr,
  input  logic [WordW-1:0] opBData,
  output logic [AddrW-1:0] opMAddr,
  input  logic [WordW-1:0] opMData,
  output logic [AddrW-1:0] resultAddr,
  output logic [WordW-1:0] resultData,
  output logic             resultWe
);
  localparam int BitW = $clog2(WordW);

  dpStrobe_t        strobe;
  logic [AddrW-1:0] wordIdx;
  logic [AddrW-1:0] bWordIdx;
  logic [BitW-1:0]  bitSel;

  mont_ctrl #(.AddrW(AddrW), .WordW(WordW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .calculate (calculate),
    .length    (length),
    .ready     (ready),
    .strobe    (strobe),
    .wordIdx   (wordIdx),
    .bWordIdx  (bWordIdx),
    .bitSel    (bitSel)
  );

  mont_dp #(.AddrW(AddrW), .WordW(WordW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wordIdx    (wordIdx),
    .bitSel     (bitSel),
    .opAData    (opAData),
    .opBData    (opBData),
    .opMData    (opMData),
    .resultAddr (resultAddr),
    .resultData (resultData),
    .resultWe   (resultWe)
  );

  assign opAAddr = wordIdx;
  assign opMAddr = wordIdx;
  assign opBAddr = bWordIdx;

  a_r6_no_write_when_ready: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> !ready);

  a_r6_ready_after_last_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> !$past(resultWe));

endmodule

// File: tb/mont_mul_bench.sv
`timescale 1ns/100ps
module mont_mul_bench;
  localparam int NumVec = 8;

  typedef struct packed {
    logic [31:0]  len;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] m;
    logic [127:0] exp;
    logic         exact;
  } vec_t;

  localparam vec_t Vecs [NumVec] = '{
    '{32'd1, 128'h9, 128'h7, 128'h13, 128'h1, 1'b1},
    '{32'd1, 128'h2, 128'hA, 128'hB, 128'h5, 1'b1},
    '{32'd3, 128'h1, 128'h4000, 128'h1ffffff_ffffffff_ffffffff, 128'h80, 1'b1},
    '{32'd1, 128'h12345, 128'h6789, 128'h3fffffb, 128'h0, 1'b0},
    '{32'd2, 128'h1_23456789, 128'hABCDEF01, 128'h0fffffff_ffffffc5, 128'h0, 1'b0},
    '{32'd4, 128'h00112233_44556677_8899aabb_ccddeeff,
             128'h00234567_89abcdef_01234567_89abcdef,
             128'h01234567_89abcdef_fedcba98_76543211, 128'h0, 1'b0},
    '{32'd4, 128'h0,
             128'h00234567_89abcdef_01234567_89abcdef,
             128'h01234567_89abcdef_fedcba98_76543211, 128'h0, 1'b0},
    '{32'd2, 128'h3fffffff_fffffffe, 128'h3fffffff_fffffffe,
             128'h3fffffff_ffffffff, 128'h0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  length = '0;
  logic        calculate = 1'b0;
  logic        ready;
  logic [7:0]  opAAddr, opBAddr, opMAddr, resultAddr;
  logic [31:0] opAData, opBData, opMData, resultData;
  logic        resultWe;

  int          curLen = 1;
  logic [127:0] curA = '0, curB = '0, curM = '0;
  int          tests = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  mont_mul u_mont_mul (
    .clk(clk), .rstN(rstN), .length(length), .calculate(calculate), .ready(ready),
    .opAAddr(opAAddr), .opAData(opAData), .opBAddr(opBAddr), .opBData(opBData),
    .opMAddr(opMAddr), .opMData(opMData), .resultAddr(resultAddr),
    .resultData(resultData), .resultWe(resultWe)
  );

  // Word 0 is the most significant word (R4).
  function automatic logic [31:0] wordOf(input logic [127:0] v, input int len, input logic [7:0] idx);
    logic [127:0] sh;
    if (int'(idx) >= len) return 32'h0;
    sh = v >> ((len - 1 - int'(idx)) * 32);
    return sh[31:0];
  endfunction

  always @(posedge clk) begin
    opAData <= wordOf(curA, curLen, opAAddr);
    opBData <= wordOf(curB, curLen, opBAddr);
    opMData <= wordOf(curM, curLen, opMAddr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input int len, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] m, input int busyPulse,
                       output logic [127:0] res, output int nWr, output bit ordOk);
    curLen = len; curA = a; curB = b; curM = m;
    res = '0; nWr = 0; ordOk = 1'b1;
    @(negedge clk);
    length = 8'(len); calculate = 1'b1;
    @(negedge clk);
    calculate = 1'b0;
    check(ready == 1'b0, "R2", "ready after start", 256'(ready), 256'(0));
    for (int c = 0; c < 30000; c++) begin
      if (resultWe) begin
        if (int'(resultAddr) != nWr) ordOk = 1'b0;
        if (int'(resultAddr) < len) res[(len - 1 - int'(resultAddr)) * 32 +: 32] = resultData;
        nWr++;
      end
      if (ready) break;
      if (c == busyPulse) begin
        length = 8'(len + 1); calculate = 1'b1;
      end else begin
        calculate = 1'b0;
      end
      @(negedge clk);
    end
    calculate = 1'b0;
    check(ready == 1'b1, "R6", "run completes", 256'(ready), 256'(1));
  endtask

  task automatic checkResult(input string tag, input int len, input logic [127:0] a,
                             input logic [127:0] b, input logic [127:0] m,
                             input logic [127:0] res);
    logic [255:0] lhs, rhs;
    lhs = ({128'b0, res} << (32 * len)) % {128'b0, m};
    rhs = ({128'b0, a} * {128'b0, b}) % {128'b0, m};
    check(lhs == rhs, tag, "r*R mod M vs A*B mod M", lhs, rhs);
    check(res < (m << 1), tag, "result below 2M", 256'(res), 256'(m << 1));
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] res, res2;
    int nWr;
    bit ordOk;
    bit sawWrite;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1", "ready in reset", 256'(ready), 256'(1));
    check(resultWe == 1'b0, "R1", "resultWe in reset", 256'(resultWe), 256'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1", "ready after reset", 256'(ready), 256'(1));

    // R8: zero length start is ignored
    length = 8'd0; calculate = 1'b1;
    @(negedge clk);
    calculate = 1'b0;
    check(ready == 1'b1, "R8", "ready after zero-length start", 256'(ready), 256'(1));
    sawWrite = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (resultWe || !ready) sawWrite = 1'b1;
    end
    check(sawWrite == 1'b0, "R8", "no activity after zero-length start", 256'(sawWrite), 256'(0));

    // Vector table: R3, R4, R5, R9
    for (int i = 0; i < NumVec; i++) begin
      runOp(int'(Vecs[i].len), Vecs[i].a, Vecs[i].b, Vecs[i].m, -1, res, nWr, ordOk);
      check(nWr == int'(Vecs[i].len), "R5", "write count", 256'(nWr), 256'(Vecs[i].len));
      check(ordOk, "R5", "write addresses ascend from 0", 256'(ordOk), 256'(1));
      checkResult("R3", int'(Vecs[i].len), Vecs[i].a, Vecs[i].b, Vecs[i].m, res);
      if (Vecs[i].exact)
        check(res == Vecs[i].exp, "R9", "exact product, word order R4", 256'(res), 256'(Vecs[i].exp));
    end

    // R7: start pulse while busy is ignored
    runOp(int'(Vecs[5].len), Vecs[5].a, Vecs[5].b, Vecs[5].m, 40, res2, nWr, ordOk);
    check(nWr == 4, "R7", "write count with busy start", 256'(nWr), 256'(4));
    checkResult("R7", 4, Vecs[5].a, Vecs[5].b, Vecs[5].m, res2);
    sawWrite = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (resultWe || !ready) sawWrite = 1'b1;
    end
    check(sawWrite == 1'b0, "R7", "no second run after busy start", 256'(sawWrite), 256'(0));

    // R6: ready is back and stays with no writes
    check(ready == 1'b1 && resultWe == 1'b0, "R6", "idle after run",
          256'({ready, resultWe}), 256'(2'b10));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule